// File: doc/BRIEF.md
# VGA CPU Plane Address Decoder

This block sits between the host side of a VGA-style display memory and its four byte-wide planes. For each CPU access it takes the byte offset inside the display memory window and works out which planes take part and at which address inside those planes. Three memory organisations are supported: a chained layout in which consecutive bytes rotate across the four planes, a paired layout used by text modes in which even and odd bytes go to different plane pairs, and a plain planar layout in which every plane sees the same linear address.

The organisation is picked from a handful of configuration bits. These bits are sampled in the same clock as the request strobe. One clock later the block presents a registered plane-enable mask, a translated in-plane offset and a one-cycle valid pulse. Write gating by a per-plane mask, data latches and raster operations belong to downstream logic. A build parameter chooses what the high-page bit does in paired mode: either it is ignored and both plane pairs are mirrored, or it steers the access to the upper pair only.

Top module: `vplane_addr_xlate`

## Requirements
- R1: While reset is asserted, and until the first request after reset, `vld_o` is 0, `mask_o` is 0 and `pofs_o` is 0.
- R2: A request with `req_i`=1 at a rising edge gives `vld_o`=1 for exactly the next cycle. In a cycle after no request, `vld_o` is 0.
- R3: Chain mode (`chain4_i`=1) wins over every other setting. `mask_o` has bit `ofs_i[1:0]` set and no other bit, and `pofs_o` = `ofs_i` >> 2.
- R4: When `chain4_i`=0 and at least one of `gm_oe_i`, `mg_oe_i` or `sq_oe_i` is 0, the block uses planar mode. Paired mode is used only when all three are 1.
- R5: In planar mode a write (`wr_i`=1) gives `mask_o`=4'hF.
- R6: In planar mode a read (`wr_i`=0) gives `mask_o` with only bit `rmap_i` set (rmap 0 gives 4'h1, 3 gives 4'h8).
- R7: In planar mode `pofs_o` equals `ofs_i` unchanged, all 17 bits.
- R8: In paired mode with the default build (`HIPAGE_EXCL`=0), `mask_o` is 4'h5 when `ofs_i[0]`=0 and 4'hA when `ofs_i[0]`=1. `hipage_i` has no effect.
- R9: In paired mode `pofs_o` holds `ofs_i[15:1]` in bits [15:1]. Bit 0 and bit 16 are 0.
- R10: With `HIPAGE_EXCL`=1, in paired mode with `hipage_i`=1, `mask_o` is 4'h4 when `ofs_i[0]`=0 and 4'h8 when `ofs_i[0]`=1. With `hipage_i`=0 it behaves as in R8.
- R11: All mode inputs, `wr_i` and `ofs_i` are sampled only together with `req_i`. Changing them without a request leaves `mask_o` and `pofs_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Access request strobe, one cycle per access |
| wr_i | input | 1 | 1 for a CPU write, 0 for a CPU read |
| ofs_i | input | 17 | Byte offset inside the display memory window |
| chain4_i | input | 1 | Chained four-plane organisation enable |
| gm_oe_i | input | 1 | Graphics-mode paired-addressing enable |
| mg_oe_i | input | 1 | Miscellaneous-graphics paired-addressing enable |
| sq_oe_i | input | 1 | Sequencer memory-mode paired-addressing enable |
| rmap_i | input | 2 | Plane selected for planar reads |
| hipage_i | input | 1 | High-page select for paired mode |
| vld_o | output | 1 | One-cycle pulse marking a new result |
| mask_o | output | 4 | Plane-enable mask, bit n for plane n |
| pofs_o | output | 17 | Translated offset within the planes |

## Verification
The checker relies on `req_i` being a clean single-cycle level at each edge. It also relies on the mode, direction and offset inputs being stable at the edge where `req_i` is high, because the expected mask and offset are worked out from their values at that edge. The bench drives every input on the falling clock edge and drops `req_i` for at least one cycle between requests, so each request is a separate transaction. Mode inputs change only while no request is pending, except in the hold scenario, which moves them on purpose with `req_i` low. The bench stays idle during the two cycles that the internal reset release takes.

// File: rtl/vplane_pkg.sv
package vplane_pkg;
  localparam int NPL   = 4;
  localparam int SEL_W = $clog2(NPL);

  typedef enum logic [1:0] {
    MD_SEQ = 2'd0,
    MD_OE  = 2'd1,
    MD_C4  = 2'd2
  } vmode_e;
endpackage

// File: rtl/vplane_rst_sync.sv
module vplane_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/vplane_mode_sel.sv
module vplane_mode_sel
  import vplane_pkg::*;
(
  input  logic   chain4_i,
  input  logic   gm_oe_i,
  input  logic   mg_oe_i,
  input  logic   sq_oe_i,
  output vmode_e mode_o
);
  logic all_oe;

  assign all_oe = gm_oe_i & mg_oe_i & sq_oe_i;

  // fixed priority: chained first, then paired, planar as fallback
  always_comb begin
    if (chain4_i)    mode_o = MD_C4;
    else if (all_oe) mode_o = MD_OE;
    else             mode_o = MD_SEQ;
  end
endmodule

// File: rtl/vplane_mask_gen.sv
module vplane_mask_gen
  import vplane_pkg::*;
#(
  parameter bit HIPAGE_EXCL = 1'b0
) (
  input  vmode_e           mode_i,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] lo_i,
  input  logic [SEL_W-1:0] rmap_i,
  input  logic             hipage_i,
  output logic [NPL-1:0]   mask_o
);
  localparam int HALF = NPL / 2;

  logic [HALF-1:0] pair;
  logic            hp_en;
  logic [NPL-1:0]  oe_mask;

  // odd byte -> odd plane of each pair
  assign pair  = lo_i[0] ? HALF'(2) : HALF'(1);
  assign hp_en = hipage_i & HIPAGE_EXCL;

  generate
    if (HIPAGE_EXCL) begin : g_excl
      assign oe_mask = {pair, hp_en ? {HALF{1'b0}} : pair};
    end else begin : g_mirror
      assign oe_mask = {pair, pair | {HALF{hp_en}}};
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      MD_C4:   mask_o = NPL'(1) << lo_i;
      MD_OE:   mask_o = oe_mask;
      default: mask_o = wr_i ? {NPL{1'b1}} : (NPL'(1) << rmap_i);
    endcase
  end
endmodule

// File: rtl/vplane_ofs_gen.sv
module vplane_ofs_gen
  import vplane_pkg::*;
#(
  parameter int OFS_W = 17,
  parameter int OE_HI = 15
) (
  input  vmode_e           mode_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [OFS_W-1:0] pofs_o
);
  logic [OFS_W-1:0] oe_keep;

  // keep mask for paired mode: bits 1..OE_HI pass, the rest are cleared
  generate
    for (genvar b = 0; b < OFS_W; b++) begin : g_keep
      assign oe_keep[b] = (b >= 1) && (b <= OE_HI);
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      MD_C4:   pofs_o = ofs_i >> SEL_W;
      MD_OE:   pofs_o = ofs_i & oe_keep;
      default: pofs_o = ofs_i;
    endcase
  end
endmodule

// File: rtl/vplane_out_reg.sv
module vplane_out_reg
  import vplane_pkg::*;
#(
  parameter int OFS_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [NPL-1:0]   mask_i,
  input  logic [OFS_W-1:0] pofs_i,
  output logic             vld_o,
  output logic [NPL-1:0]   mask_o,
  output logic [OFS_W-1:0] pofs_o
);
  logic             vld_d, vld_q;
  logic [NPL-1:0]   mask_d, mask_q;
  logic [OFS_W-1:0] pofs_d, pofs_q;

  always_comb begin
    vld_d  = en_i;
    mask_d = en_i ? mask_i : mask_q;
    pofs_d = en_i ? pofs_i : pofs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      mask_q <= '0;
      pofs_q <= '0;
    end else begin
      vld_q  <= vld_d;
      mask_q <= mask_d;
      pofs_q <= pofs_d;
    end
  end

  assign vld_o  = vld_q;
  assign mask_o = mask_q;
  assign pofs_o = pofs_q;
endmodule

// File: rtl/vplane_addr_xlate.sv
module vplane_addr_xlate
  import vplane_pkg::*;
#(
  parameter int OFS_W       = 17,
  parameter int OE_HI       = 15,
  parameter bit HIPAGE_EXCL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             chain4_i,
  input  logic             gm_oe_i,
  input  logic             mg_oe_i,
  input  logic             sq_oe_i,
  input  logic [SEL_W-1:0] rmap_i,
  input  logic             hipage_i,
  output logic             vld_o,
  output logic [NPL-1:0]   mask_o,
  output logic [OFS_W-1:0] pofs_o
);
  logic             rst_sync_n;
  vmode_e           mode;
  logic [NPL-1:0]   mask_c;
  logic [OFS_W-1:0] pofs_c;

  vplane_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vplane_mode_sel u_mode (
    .chain4_i (chain4_i),
    .gm_oe_i  (gm_oe_i),
    .mg_oe_i  (mg_oe_i),
    .sq_oe_i  (sq_oe_i),
    .mode_o   (mode)
  );

  vplane_mask_gen #(.HIPAGE_EXCL(HIPAGE_EXCL)) u_mask (
    .mode_i   (mode),
    .wr_i     (wr_i),
    .lo_i     (ofs_i[SEL_W-1:0]),
    .rmap_i   (rmap_i),
    .hipage_i (hipage_i),
    .mask_o   (mask_c)
  );

  vplane_ofs_gen #(.OFS_W(OFS_W), .OE_HI(OE_HI)) u_ofs (
    .mode_i (mode),
    .ofs_i  (ofs_i),
    .pofs_o (pofs_c)
  );

  vplane_out_reg #(.OFS_W(OFS_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en_i   (req_i),
    .mask_i (mask_c),
    .pofs_i (pofs_c),
    .vld_o  (vld_o),
    .mask_o (mask_o),
    .pofs_o (pofs_o)
  );
endmodule

// File: rtl/vplane_addr_xlate_chk.sv
module vplane_addr_xlate_chk #(
  parameter int OFS_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic             wr_i,
  input logic [OFS_W-1:0] ofs_i,
  input logic             chain4_i,
  input logic             gm_oe_i,
  input logic             mg_oe_i,
  input logic             sq_oe_i,
  input logic             vld_o,
  input logic [3:0]       mask_o,
  input logic [OFS_W-1:0] pofs_o
);
  logic c4_req, oe_req, seq_req;

  assign c4_req  = req_i && chain4_i;
  assign oe_req  = req_i && !chain4_i && gm_oe_i && mg_oe_i && sq_oe_i;
  assign seq_req = req_i && !chain4_i && !(gm_oe_i && mg_oe_i && sq_oe_i);

  p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> vld_o);
  p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !vld_o);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(mask_o) && $stable(pofs_o)));
  p_c4_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c4_req |=> ($countones(mask_o) == 1 && mask_o[$past(ofs_i[1:0])]));
  p_c4_ofs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c4_req |=> (pofs_o == ($past(ofs_i) >> 2)));
  p_seq_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && wr_i) |=> (mask_o == 4'hF));
  p_seq_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && !wr_i) |=> ($countones(mask_o) == 1));
  p_seq_ofs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req |=> (pofs_o == $past(ofs_i)));
  p_oe_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_req |=> ((mask_o[3] ^ mask_o[2]) && (mask_o[3] == $past(ofs_i[0]))));
  p_oe_ofs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_req |=> (pofs_o[0] == 1'b0 && pofs_o[OFS_W-1:1] == $past(ofs_i[OFS_W-1:1]) % (1 << (OFS_W-2))));
endmodule

bind vplane_addr_xlate vplane_addr_xlate_chk #(.OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .req_i    (req_i),
  .wr_i     (wr_i),
  .ofs_i    (ofs_i),
  .chain4_i (chain4_i),
  .gm_oe_i  (gm_oe_i),
  .mg_oe_i  (mg_oe_i),
  .sq_oe_i  (sq_oe_i),
  .vld_o    (vld_o),
  .mask_o   (mask_o),
  .pofs_o   (pofs_o)
);

// File: tb/vplane_addr_xlate_test.sv
module vplane_addr_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, wr, c4, gm, mg, sq, hp;
  logic [1:0]  rmap;
  logic [16:0] ofs;
  logic        vld_a, vld_b;
  logic [3:0]  mask_a, mask_b;
  logic [16:0] pofs_a, pofs_b;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vplane_addr_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .ofs_i(ofs),
    .chain4_i(c4), .gm_oe_i(gm), .mg_oe_i(mg), .sq_oe_i(sq),
    .rmap_i(rmap), .hipage_i(hp),
    .vld_o(vld_a), .mask_o(mask_a), .pofs_o(pofs_a)
  );

  vplane_addr_xlate #(.HIPAGE_EXCL(1'b1)) uut_hp (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .ofs_i(ofs),
    .chain4_i(c4), .gm_oe_i(gm), .mg_oe_i(mg), .sq_oe_i(sq),
    .rmap_i(rmap), .hipage_i(hp),
    .vld_o(vld_b), .mask_o(mask_b), .pofs_o(pofs_b)
  );

  function automatic logic [3:0] ref_mask(input logic excl);
    if (c4) return 4'b1 << ofs[1:0];
    if (gm && mg && sq) begin
      if (excl && hp) return ofs[0] ? 4'h8 : 4'h4;
      return ofs[0] ? 4'hA : 4'h5;
    end
    return wr ? 4'hF : (4'b1 << rmap);
  endfunction

  function automatic logic [16:0] ref_ofs();
    if (c4) return ofs >> 2;
    if (gm && mg && sq) return {1'b0, ofs[15:1], 1'b0};
    return ofs;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic set_mode(input logic c, input logic g, input logic m, input logic s,
                          input logic w, input logic [1:0] r, input logic h,
                          input logic [16:0] o);
    c4 = c; gm = g; mg = m; sq = s; wr = w; rmap = r; hp = h; ofs = o;
  endtask

  // issue one request at the current negedge and compare at the next negedge
  task automatic access(input string tag);
    logic [3:0]  ea, eb;
    logic [16:0] eo;
    ea = ref_mask(1'b0);
    eb = ref_mask(1'b1);
    eo = ref_ofs();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " mask"}, 32'(mask_a), 32'(ea));
    chk({tag, " ofs"}, 32'(pofs_a), 32'(eo));
    chk({tag, " mask hp build"}, 32'(mask_b), 32'(eb));
    chk({tag, " ofs hp build"}, 32'(pofs_b), 32'(eo));
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 vld in reset", 32'(vld_a), 0);
    chk("R1 mask in reset", 32'(mask_a), 0);
    chk("R1 ofs in reset", 32'(pofs_a), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 vld after reset", 32'(vld_a), 0);
    chk("R1 mask after reset", 32'(mask_a), 0);
    chk("R1 ofs after reset", 32'(pofs_a), 0);
  endtask

  task automatic t_valid();
    set_mode(0, 0, 0, 0, 1, 0, 0, 17'h00123);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R2 vld pulse high", 32'(vld_a), 1);
    @(negedge clk);
    chk("R2 vld pulse one cycle", 32'(vld_a), 0);
    @(negedge clk);
    chk("R2 vld stays low", 32'(vld_a), 0);
  endtask

  task automatic t_chain4();
    for (int i = 0; i < 4; i++) begin
      set_mode(1, 1, 1, 1, i[0], 2'(3 - i), 1, 17'h1ABC0 + 17'(i));
      access("R3 chain priority");
    end
    set_mode(1, 0, 1, 0, 0, 1, 0, 17'h1FFFF);
    access("R3 chain top offset");
  endtask

  task automatic t_seq();
    set_mode(0, 1, 1, 0, 1, 2, 1, 17'h10001);
    access("R5 planar write");
    for (int r = 0; r < 4; r++) begin
      set_mode(0, 0, 1, 1, 0, 2'(r), 0, 17'h0F00F);
      access("R6 planar read map");
    end
    set_mode(0, 1, 0, 1, 0, 3, 1, 17'h1FFFF);
    access("R7 planar offset passes");
  endtask

  task automatic t_oddeven();
    set_mode(0, 1, 1, 1, 1, 0, 0, 17'h00010);
    access("R8 paired even");
    set_mode(0, 1, 1, 1, 0, 3, 0, 17'h00011);
    access("R8 paired odd");
    set_mode(0, 1, 1, 1, 1, 0, 1, 17'h00011);
    access("R8 high page ignored");
    set_mode(0, 1, 1, 1, 0, 0, 0, 17'h1FFFF);
    access("R9 paired offset clears bit16 and bit0");
    set_mode(0, 1, 1, 1, 1, 0, 1, 17'h0ABCC);
    access("R10 high page even");
    set_mode(0, 1, 1, 1, 0, 0, 1, 17'h0ABCD);
    access("R10 high page odd");
  endtask

  task automatic t_hold();
    set_mode(0, 1, 1, 1, 0, 0, 0, 17'h01235);
    access("R11 setup");
    set_mode(1, 0, 0, 0, 1, 3, 1, 17'h1FFFE);
    repeat (3) @(negedge clk);
    chk("R11 mask held", 32'(mask_a), 32'h0A);
    chk("R11 ofs held", 32'(pofs_a), 32'h01234);
    chk("R11 no vld", 32'(vld_a), 0);
  endtask

  task automatic t_sweep();
    logic [16:0] offs [7];
    offs = '{17'h0, 17'h1, 17'h2, 17'h3, 17'h1FFFF, 17'h12345, 17'h0ABCD};
    for (int m = 0; m < 16; m++)
      for (int w = 0; w < 2; w++)
        for (int r = 0; r < 4; r++)
          for (int h = 0; h < 2; h++)
            for (int k = 0; k < 7; k++) begin
              set_mode(m[3], m[2], m[1], m[0], w[0], 2'(r), h[0], offs[k]);
              access("R4 sweep");
            end
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0;
    set_mode(0, 0, 0, 0, 0, 0, 0, '0);
    repeat (3) @(negedge clk);
    t_reset();
    t_valid();
    t_chain4();
    t_seq();
    t_oddeven();
    t_hold();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule